// File: doc/BRIEF.md
# Area-Based External Bus Controller

This block turns single read or write requests from the chip's internal side into cycles on an external memory bus. It first checks that the 24-bit request address lies in an external region and picks that region's configuration register. It then runs a cycle of two or more clock states. During the cycle it drives chip select, a read or write strobe, the address and the write data. For reads it captures the returned data. The requester sees a one-cycle `done_o` pulse once the access has finished.

Each area register chooses three things: a bus width of 8 or 16 bits, a cycle of 2 or 3 states, and 0 to 3 automatic wait states. Wait states are only used in 3-state areas. A slow device can hold the external wait input high to stretch a cycle further. A 16-bit access to an 8-bit area is split into two byte cycles. The registers are written through a small select/data port. They reset to the slowest timing, so any device is safe to access before software programs them.

Top module: `ext_bus_ctrl`

## Requirements
- R1: Areas are decoded as follows. 0x080000..0xFBFFFF, 0xFC0000..0xFCFFFF and 0xFF0000..0xFF9FFF all use register select 0. 0xFD0000..0xFDFFFF uses select 1. 0xFE0000..0xFEFFFF uses select 2.
- R2: A request to any other address starts no cycle: chip select stays low, no strobe is driven and no done pulse is given.
- R3: After reset, every area register reads as 16-bit, 3-state, 3 wait states. A first word read therefore holds chip select high for 6 clocks.
- R4: In a 2-state area, every cycle lasts exactly 2 clocks. The wait count field and the external wait input have no effect.
- R5: In a 3-state area with N programmed waits, a cycle lasts 3+N clocks, as long as the external wait input stays low.
- R6: The external wait input is sampled only in the last programmed wait state. Each sample taken high adds one more wait state. With N=0 the input is ignored.
- R7: Chip select is high in every state of a cycle. The read or write strobe is low in the first state and high from the second state to the end. The address does not change while a strobe is high, and for writes the data output is enabled for the whole cycle.
- R8: A word access to an 8-bit area runs two back-to-back byte cycles: first at the even address, carrying the high byte, then at the odd address. Done is given only after the second cycle.
- R9: Byte lanes follow these rules. A 16-bit area uses data[15:8] for even addresses and data[7:0] for odd addresses. An 8-bit area always uses data[7:0]. Write bytes are driven on both lanes. A byte read returns the byte in rdata[7:0], with rdata[15:8] set to zero.
- R10: `done_o` is a one-clock pulse in the clock after the last state, with `rdata_o` valid and `busy_o` low. A request made while `busy_o` is high is ignored.
- R11: The register format is bit 3 = width (1 = 16-bit), bit 2 = states (1 = 3-state), bits 1:0 = wait count. A write to select 3 changes nothing. A running cycle keeps the settings it latched at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Area register write enable |
| cfg_sel_i | input | 2 | Area register select |
| cfg_wdata_i | input | 4 | Area register write value |
| req_i | input | 1 | Access request, taken when idle |
| addr_i | input | 24 | Request byte address |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| wdata_i | input | 16 | Write data (byte access uses [7:0]) |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Access finished pulse |
| rdata_o | output | 16 | Read data |
| ext_cs_o | output | 1 | External chip select, active high |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |
| ext_addr_o | output | 24 | External address |
| ext_data_o | output | 16 | External write data |
| ext_data_oe_o | output | 1 | External data output enable |
| ext_data_i | input | 16 | External read data |
| ext_wait_i | input | 1 | External wait request |

## Verification
The hardest case to reach from the ports is the wait input taking effect only in the last programmed wait state, and especially when that state falls inside the second half of a split word access. The bench builds an expected cycle list for each access, with one entry per clock. It drives the wait input from that list by state index, so the extra samples land exactly in the last programmed wait state. Separate runs hold the wait input high throughout 2-state and zero-wait cycles to show it is ignored there. Another run raises a second request in the middle of a cycle and shows it is dropped.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef struct packed {
    logic       wide;   // 1: 16-bit bus
    logic       slow;   // 1: 3-state cycle
    logic [1:0] waits;
  } area_cfg_t;

  localparam area_cfg_t CFG_RESET = '{wide: 1'b1, slow: 1'b1, waits: 2'd3};

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} bus_st_e;
endpackage

// File: rtl/ebc_area_decode.sv
module ebc_area_decode #(
  parameter int ADDR_W = 24,
  parameter int SEL_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam logic [ADDR_W-1:0] BASIC_LO = ADDR_W'(24'h080000);
  localparam logic [ADDR_W-1:0] BASIC_HI = ADDR_W'(24'hFBFFFF);
  localparam logic [ADDR_W-1:0] TOP_LO   = ADDR_W'(24'hFF0000);
  localparam logic [ADDR_W-1:0] TOP_HI   = ADDR_W'(24'hFF9FFF);
  localparam logic [7:0]        AREA_PG  = 8'hFC;

  logic [7:0] page;
  assign page = addr_i[ADDR_W-1 -: 8];

  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    if (addr_i >= BASIC_LO && addr_i <= BASIC_HI) begin
      hit_o = 1'b1;
    end else if (page >= AREA_PG && page <= AREA_PG + 8'd2) begin
      hit_o = 1'b1;
      sel_o = SEL_W'(page - AREA_PG);
    end else if (addr_i >= TOP_LO && addr_i <= TOP_HI) begin
      hit_o = 1'b1;
    end
  end
endmodule

// File: rtl/ebc_cfg_regs.sv
module ebc_cfg_regs
  import ebc_pkg::*;
#(
  parameter int NUM_AREAS = 3,
  parameter int SEL_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     wsel_i,
  input  logic [3:0]           wdata_i,
  input  logic [SEL_W-1:0]     rsel_i,
  output area_cfg_t            cfg_o
);
  area_cfg_t regs_q [NUM_AREAS];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= CFG_RESET;
      else if (we_i && wsel_i == SEL_W'(g))    regs_q[g] <= area_cfg_t'(wdata_i);
    end
  end

  always_comb begin
    cfg_o = CFG_RESET;
    for (int i = 0; i < NUM_AREAS; i++)
      if (rsel_i == SEL_W'(i)) cfg_o = regs_q[i];
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              hit_i,
  input  area_cfg_t         cfg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ext_cs_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              ext_wait_i
);
  localparam int BYTE_W = DATA_W / 2;

  bus_st_e           st_q;
  area_cfg_t         cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q, word_q, split_q, second_q, done_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        wcnt_q;
  logic              cyc_end, strobe;
  logic [BYTE_W-1:0] lane_byte;

  assign cyc_end   = (st_q == S_T2 && !cfg_q.slow) || st_q == S_T3;
  assign strobe    = st_q == S_T2 || st_q == S_TW || st_q == S_T3;
  assign lane_byte = (cfg_q.wide && !addr_q[0]) ? ext_data_i[DATA_W-1:BYTE_W]
                                                : ext_data_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cfg_q    <= CFG_RESET;
      addr_q   <= '0;
      we_q     <= 1'b0;
      word_q   <= 1'b0;
      split_q  <= 1'b0;
      second_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      wcnt_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (req_i && hit_i) begin
          cfg_q    <= cfg_i;
          we_q     <= we_i;
          word_q   <= word_i;
          split_q  <= word_i && !cfg_i.wide;
          second_q <= 1'b0;
          wdata_q  <= wdata_i;
          addr_q   <= (word_i && !cfg_i.wide) ? {addr_i[ADDR_W-1:1], 1'b0} : addr_i;
          st_q     <= S_T1;
        end
        S_T1: st_q <= S_T2;
        S_T2: if (cfg_q.slow) begin
          if (cfg_q.waits == 2'd0) st_q <= S_T3;
          else begin
            st_q   <= S_TW;
            wcnt_q <= cfg_q.waits;
          end
        end
        S_TW: begin
          if (wcnt_q > 2'd1)    wcnt_q <= wcnt_q - 2'd1;
          else if (!ext_wait_i) st_q   <= S_T3;  // last programmed wait: pin extends
        end
        default: ;
      endcase
      if (cyc_end) begin
        if (!we_q) begin
          if (word_q && cfg_q.wide)   rdata_q <= ext_data_i;
          else if (split_q && !second_q) rdata_q[DATA_W-1:BYTE_W] <= lane_byte;
          else if (split_q)           rdata_q[BYTE_W-1:0] <= lane_byte;
          else                        rdata_q <= {{BYTE_W{1'b0}}, lane_byte};
        end
        if (split_q && !second_q) begin
          second_q  <= 1'b1;
          addr_q[0] <= 1'b1;
          st_q      <= S_T1;
        end else begin
          st_q   <= S_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (word_q && cfg_q.wide)      ext_data_o = wdata_q;
    else if (split_q && !second_q) ext_data_o = {2{wdata_q[DATA_W-1:BYTE_W]}};
    else                           ext_data_o = {2{wdata_q[BYTE_W-1:0]}};
  end

  assign busy_o        = st_q != S_IDLE;
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;
  assign ext_cs_o      = st_q != S_IDLE;
  assign ext_rd_o      = strobe && !we_q;
  assign ext_wr_o      = strobe && we_q;
  assign ext_addr_o    = addr_q;
  assign ext_data_oe_o = we_q && st_q != S_IDLE;
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int NUM_AREAS = 3,
  parameter int SEL_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [3:0]        cfg_wdata_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ext_cs_o,
  output logic              ext_rd_o,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              ext_wait_i
);
  logic             hit;
  logic [SEL_W-1:0] sel;
  area_cfg_t        cfg;

  ebc_area_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
    .addr_i(addr_i), .hit_o(hit), .sel_o(sel)
  );

  ebc_cfg_regs #(.NUM_AREAS(NUM_AREAS), .SEL_W(SEL_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wsel_i(cfg_sel_i),
    .wdata_i(cfg_wdata_i), .rsel_i(sel), .cfg_o(cfg)
  );

  ebc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .hit_i(hit), .cfg_i(cfg),
    .addr_i(addr_i), .we_i(we_i), .word_i(word_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .ext_cs_o(ext_cs_o), .ext_rd_o(ext_rd_o), .ext_wr_o(ext_wr_o),
    .ext_addr_o(ext_addr_o), .ext_data_o(ext_data_o),
    .ext_data_oe_o(ext_data_oe_o), .ext_data_i(ext_data_i),
    .ext_wait_i(ext_wait_i)
  );
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ext_cs_o,
  input logic              ext_rd_o,
  input logic              ext_wr_o,
  input logic [ADDR_W-1:0] ext_addr_o
);
  logic miss;
  assign miss = addr_i < ADDR_W'(24'h080000) || addr_i > ADDR_W'(24'hFF9FFF);

  // R7
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rd_o || ext_wr_o) |-> ext_cs_o);
  // R7
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rd_o && ext_wr_o));
  // R7
  first_state_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_cs_o) |-> !ext_rd_o && !ext_wr_o);
  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ext_rd_o || ext_wr_o) && $past(ext_rd_o || ext_wr_o)) |-> $stable(ext_addr_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ext_cs_o && !busy_o);
  // R2
  miss_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && miss) |=> !ext_cs_o);
endmodule

bind ext_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W)) u_ebc_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
  .busy_o(busy_o), .done_o(done_o), .ext_cs_o(ext_cs_o), .ext_rd_o(ext_rd_o),
  .ext_wr_o(ext_wr_o), .ext_addr_o(ext_addr_o)
);

// File: tb/ext_bus_ctrl_test.sv
module ext_bus_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [3:0]  cfg_wdata_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, done_o, ext_cs_o, ext_rd_o, ext_wr_o, ext_data_oe_o;
  logic [15:0] rdata_o, ext_data_o, ext_data_i;
  logic [23:0] ext_addr_o;
  logic        ext_wait_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit [3:0] mcfg [3] = '{4'hF, 4'hF, 4'hF};

  typedef struct {
    bit cs; bit rd; bit wr; bit done; bit wt; bit chk_rd;
    bit [23:0] addr; bit [15:0] wd; bit [15:0] rexp;
  } exp_t;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // external device: returns address-derived data
  assign ext_data_i = {~ext_addr_o[7:0], ext_addr_o[7:0] ^ 8'h3C};

  ext_bus_ctrl uut (.*);

  function automatic bit [7:0] hi_b(bit [23:0] a); return ~a[7:0]; endfunction
  function automatic bit [7:0] lo_b(bit [23:0] a); return a[7:0] ^ 8'h3C; endfunction

  function automatic int area_of(bit [23:0] a);
    if (a >= 24'h080000 && a <= 24'hFCFFFF) return 0;
    if (a[23:16] == 8'hFD) return 1;
    if (a[23:16] == 8'hFE) return 2;
    if (a >= 24'hFF0000 && a <= 24'hFF9FFF) return 0;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [3:0] val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (sel < 2'd3) mcfg[sel] = val;
  endtask

  task automatic run(string tag, bit [23:0] a, bit we, bit word, bit [15:0] wd,
                     int extra, bit wt_all, bit poke);
    exp_t q[$];
    exp_t e;
    int area, w, n, nb;
    bit wide, slow, split;
    bit [23:0] ca;
    bit [7:0] lb;
    bit [15:0] rexp;
    area = area_of(a);
    rexp = '0;
    if (area < 0) begin
      repeat (3) begin e = '{default: 0}; q.push_back(e); end
    end else begin
      wide = mcfg[area][3]; slow = mcfg[area][2]; w = int'(mcfg[area][1:0]);
      split = word && !wide;
      nb = split ? 2 : 1;
      for (int b = 0; b < nb; b++) begin
        ca = split ? {a[23:1], b[0]} : a;
        n = slow ? 3 + w + ((w > 0) ? extra : 0) : 2;
        for (int i = 0; i < n; i++) begin
          e = '{default: 0};
          e.cs = 1; e.rd = !we && i > 0; e.wr = we && i > 0; e.addr = ca;
          if (word && wide) e.wd = wd;
          else if (split && b == 0) e.wd = {2{wd[15:8]}};
          else e.wd = {2{wd[7:0]}};
          e.wt = wt_all || (slow && w > 0 && i >= 1 + w && i < 1 + w + extra);
          q.push_back(e);
        end
        lb = (wide && !ca[0]) ? hi_b(ca) : lo_b(ca);
        if (word && wide) rexp = {hi_b(ca), lo_b(ca)};
        else if (split && b == 0) rexp[15:8] = lb;
        else if (split) rexp[7:0] = lb;
        else rexp = {8'h00, lb};
      end
      e = '{default: 0}; e.done = 1; e.chk_rd = !we; e.rexp = rexp; q.push_back(e);
      e = '{default: 0}; q.push_back(e);
    end
    @(negedge clk_i);
    req_i = 1'b1; addr_i = a; we_i = we; word_i = word; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    foreach (q[k]) begin
      chk(tag, "cs/rd/wr/done", {28'd0, ext_cs_o, ext_rd_o, ext_wr_o, done_o},
          {28'd0, q[k].cs, q[k].rd, q[k].wr, q[k].done});
      if (q[k].cs) chk(tag, "addr", {8'd0, ext_addr_o}, {8'd0, q[k].addr});
      if (q[k].cs && we)
        chk(tag, "wdata/oe", {15'd0, ext_data_oe_o, ext_data_o}, {15'd0, 1'b1, q[k].wd});
      if (q[k].chk_rd) chk(tag, "rdata", {16'd0, rdata_o}, {16'd0, q[k].rexp});
      if (q[k].done) chk("R10", "busy at done", {31'd0, busy_o}, 32'd0);
      ext_wait_i = q[k].wt;
      if (poke && k == 1) begin req_i = 1'b1; addr_i = 24'hFE0000; end
      if (poke && k == 2) req_i = 1'b0;
      @(negedge clk_i);
    end
    ext_wait_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R10", "reset cs/busy/done", {29'd0, ext_cs_o, busy_o, done_o}, 32'd0);
    rst_ni = 1'b1;
    // R3: reset config, 16-bit 3-state 3 waits
    run("R3", 24'h100000, 0, 1, 16'h0, 0, 0, 0);
    // R11/R5: area 2 -> 16-bit, 3-state, 1 wait
    cfg_write(2'd1, 4'b1101);
    run("R5", 24'hFD0010, 0, 1, 16'h0, 0, 0, 0);
    run("R7", 24'hFD0020, 1, 1, 16'hA55A, 0, 0, 0);
    // R4: area 3 -> 2-state, wait field 3 ignored, wait pin high throughout
    cfg_write(2'd2, 4'b1011);
    run("R4", 24'hFE0020, 0, 1, 16'h0, 0, 1, 0);
    // R6: extension in last programmed wait
    run("R6", 24'hFD0100, 0, 1, 16'h0, 3, 0, 0);
    cfg_write(2'd1, 4'b1100);
    run("R6", 24'hFD0200, 0, 1, 16'h0, 0, 1, 0);
    // R8: area 1 -> 8-bit, 3-state, 1 wait
    cfg_write(2'd0, 4'b0101);
    run("R8", 24'hFC0035, 0, 1, 16'h0, 0, 0, 0);
    run("R8", 24'h200000, 1, 1, 16'hBEEF, 2, 0, 0);
    // R1: top region and basic area share select 0
    run("R1", 24'hFF0040, 0, 0, 16'h0, 0, 0, 0);
    run("R1", 24'hFF9FFF, 0, 0, 16'h0, 0, 0, 0);
    run("R1", 24'h080000, 0, 1, 16'h0, 0, 0, 0);
    // R9: byte lanes on a 16-bit area
    run("R9", 24'hFE0010, 0, 0, 16'h0, 0, 0, 0);
    run("R9", 24'hFE0011, 0, 0, 16'h0, 0, 0, 0);
    run("R9", 24'hFE0013, 1, 0, 16'h005A, 0, 0, 0);
    // R2: outside external areas
    run("R2", 24'h07FFFF, 0, 1, 16'h0, 0, 0, 0);
    run("R2", 24'hFFA000, 0, 1, 16'h0, 0, 0, 0);
    run("R2", 24'h000010, 1, 0, 16'h0, 0, 0, 0);
    // R10: request during a cycle dropped
    run("R10", 24'hFD0300, 0, 1, 16'h0, 0, 0, 1);
    // R11: select 3 write changes nothing
    cfg_write(2'd3, 4'b0000);
    run("R11", 24'hFC0002, 0, 1, 16'h0, 0, 0, 0);
    run("R11", 24'hFD0004, 0, 1, 16'h0, 0, 0, 0);
    run("R11", 24'hFE0006, 0, 1, 16'h0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule